// File: doc/BRIEF.md
# I2C Register Interface with Snapshot

This block is the serial front end of a timekeeping register file. It watches oversampled SCL and SDA lines from the pads, recognises START, repeated START and STOP conditions, answers a fixed 7-bit device address, and moves bytes between the bus and a 64-location map. The low eight locations are the clock registers and a control byte; the rest is general-purpose RAM. An auto-incrementing pointer selects the location; a write transaction loads it from its first data byte, and a read continues from wherever it was left.

Reads of the seven time registers come from a shadow copy taken at each START and whenever the pointer rolls over to location zero, so a burst read returns one coherent instant while the counters keep running. Writes to those registers are not stored here: they leave the block on a write port to the live counters, in the acknowledge cycle, with a separate pulse that restarts the sub-second divider when the seconds byte is written. The control byte lives in the block; two status flags in it are set by hardware and can only be cleared over the bus. A slow tick drives a watchdog that returns the interface to idle when SCL stays low too long.

The controller is a state machine with states IDLE, ADDR (shift in the address byte), ADDR_ACK (acknowledge the address), RXB (shift in a pointer or data byte), RXB_ACK (acknowledge it), TXB (shift out a data byte), MACK (read the master's acknowledge) and IGNORE (stay silent). Transitions: any START goes to ADDR; STOP and the watchdog go to IDLE; ADDR goes to ADDR_ACK on a match and to IGNORE otherwise; ADDR_ACK goes to TXB for a read and RXB for a write; RXB and RXB_ACK alternate; TXB goes to MACK; MACK goes to TXB on an acknowledge and to IGNORE on a not-acknowledge.

Top module: `i2c_timereg_port`

## Requirements
- R1: The device address is 7'b1101000 in bits 7..1 of the first byte after a START, bit 0 selects direction (0 write, 1 read), so D0h and D1h are acknowledged by pulling SDA low in the ninth clock.
- R2: After a first byte whose address bits differ, the block drives SDA for nothing (no acknowledge, no data) and leaves its map unchanged until the next START.
- R3: In a write transaction the first byte after the address loads the pointer (its low 6 bits); every later byte is stored at the pointer and the pointer then increments.
- R4: A read returns bytes starting at the current pointer, so a write of the pointer followed by a repeated START and D1h reads from the chosen location, and a plain START with D1h continues where the pointer was left.
- R5: Locations 00h..06h are time registers, 07h is the control byte, 08h..3Fh are 56 RAM bytes; the pointer increments from 3Fh to 00h.
- R6: Reads of 00h..06h return the shadow, which is reloaded from the live time inputs at every START (including repeated START) and whenever the pointer increments to 00h, and at no other time.
- R7: A byte written to 00h..06h appears on the live-counter write port (enable, index, data) while the block acknowledges it; a write to 00h also raises the divider-restart pulse, a write elsewhere does not.
- R8: When SCL stays low for TO_TICKS timebase ticks, the block returns to IDLE and releases SDA, and the next START is accepted normally; shorter low periods have no effect.
- R9: SDA is driven or released only while SCL is low; write bits are sampled on SCL rising edges and read bits are changed after SCL falling edges (MSB first).
- R10: The control byte resets to B3h; bits 5 and 3 are sticky flags set by the osf_set and los_set inputs, a written 0 clears them and a written 1 leaves them unchanged; the other six bits take the written value.
- R11: Bits fixed at zero read as 0 and are forced to 0 on the write port; the kept-bit masks per index 0..6 are FFh, 7Fh, 7Fh, 07h, 3Fh, 1Fh, FFh.
- R12: When the master does not acknowledge a read byte, the block stops driving SDA until a STOP or START, and the pointer has still advanced past that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock from the pad, unsynchronised |
| sda_in | input | 1 | Serial data from the pad, unsynchronised |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| tick | input | 1 | One-cycle pulse of the slow timebase |
| live_time | input | 56 | Live time registers, index i in bits 8i+7..8i |
| osf_set | input | 1 | Sets control bit 5 |
| los_set | input | 1 | Sets control bit 3 |
| tw_en | output | 1 | Write strobe to the live counters |
| tw_idx | output | 3 | Time register index of the write |
| tw_data | output | 8 | Masked write data |
| chain_rst | output | 1 | Sub-second divider restart pulse |
| ctrl_q | output | 8 | Current control byte |

## Verification
The bench builds the block with TO_TICKS = 12 and a tick every 20 clocks, so the watchdog window is 240 clocks: long enough that normal 12-clock SCL low phases never approach it, short enough that both a sub-window hold and an expiring hold fit in a few hundred cycles. The address, 64-location map and 2-stage synchroniser keep their default values, which brings the 3Fh-to-00h roll-over, the wrap-time snapshot and every fixed-zero mask within reach of a short random burst sequence plus directed transfers.

// File: rtl/i2ctr_pkg.sv
package i2ctr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RXB,
        ST_RXB_ACK,
        ST_TXB,
        ST_MACK,
        ST_IGNORE
    } bus_state_t;

    localparam logic [7:0] CTRL_RESET  = 8'hB3;
    localparam logic [7:0] CTRL_STICKY = 8'h28;
    localparam logic [7:0] FLAG_OSF    = 8'h20;
    localparam logic [7:0] FLAG_LOS    = 8'h08;

    // Bits that hold information in each time register; the rest read as zero.
    function automatic logic [7:0] live_mask(input logic [2:0] idx);
        logic [7:0] m;
        case (idx)
            3'd1, 3'd2: m = 8'h7F;
            3'd3:       m = 8'h07;
            3'd4:       m = 8'h3F;
            3'd5:       m = 8'h1F;
            default:    m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/i2ctr_busin.sv
module i2ctr_busin #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_in;
                    sda_pipe <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_pipe[STAGES-1];
            sda_q <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2ctr_lowwatch.sv
module i2ctr_lowwatch #(
    parameter int LIMIT = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic tick,
    output logic fire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (scl_s) begin
                cnt <= '0;
            end else if (tick && cnt != CW'(LIMIT)) begin
                cnt <= cnt + 1'b1;
                if (cnt == CW'(LIMIT - 1)) begin
                    fire <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2ctr_regmap.sv
module i2ctr_regmap
    import i2ctr_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int TIME_REGS = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      snap_req,
    input  logic                      ptr_load,
    input  logic [ADDR_W-1:0]         load_val,
    input  logic                      wr_req,
    input  logic [7:0]                wr_val,
    input  logic                      adv_req,
    input  logic [TIME_REGS*8-1:0]    live_time,
    input  logic                      osf_set,
    input  logic                      los_set,
    output logic [7:0]                rd_val,
    output logic [7:0]                ctrl_q,
    output logic                      tw_en,
    output logic [$clog2(TIME_REGS)-1:0] tw_idx,
    output logic [7:0]                tw_data,
    output logic                      chain_rst
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int CTRL_IDX  = TIME_REGS;
    localparam int RAM_BASE  = TIME_REGS + 1;
    localparam int RAM_DEPTH = DEPTH - RAM_BASE;
    localparam int IW        = $clog2(TIME_REGS);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ram_idx;
    logic [7:0]        shadow [TIME_REGS];
    logic [7:0]        ram    [RAM_DEPTH];
    logic [7:0]        ctrl_d;
    logic              is_time;
    logic              is_ctrl;
    logic              wrap;
    logic              snap;

    assign is_time = ptr_q < ADDR_W'(TIME_REGS);
    assign is_ctrl = ptr_q == ADDR_W'(CTRL_IDX);
    assign ram_idx = ptr_q - ADDR_W'(RAM_BASE);
    assign wrap    = (ptr_q == {ADDR_W{1'b1}}) && (wr_req || adv_req);
    assign snap    = snap_req || wrap;

    // Pointer: loaded by the first written byte, stepped after every data byte.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_load) begin
            ptr_q <= load_val;
        end else if (wr_req || adv_req) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    // Read shadow of the live time registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TIME_REGS; i++) shadow[i] <= '0;
        end else if (snap) begin
            for (int i = 0; i < TIME_REGS; i++) shadow[i] <= live_time[i*8 +: 8];
        end
    end

    // General-purpose bytes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
        end else if (wr_req && !is_time && !is_ctrl) begin
            ram[ram_idx] <= wr_val;
        end
    end

    // Control byte: sticky flags are only cleared by the bus, set by hardware.
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_req && is_ctrl) begin
            ctrl_d = (wr_val & ~CTRL_STICKY) | (ctrl_q & wr_val & CTRL_STICKY);
        end
        if (osf_set) ctrl_d = ctrl_d | FLAG_OSF;
        if (los_set) ctrl_d = ctrl_d | FLAG_LOS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // Live-counter write port.
    assign tw_en     = wr_req && is_time;
    assign tw_idx    = ptr_q[IW-1:0];
    assign tw_data   = wr_val & live_mask(3'(ptr_q[IW-1:0]));
    assign chain_rst = tw_en && (ptr_q == '0);

    always_comb begin
        if (is_time) begin
            rd_val = shadow[ptr_q[IW-1:0]] & live_mask(3'(ptr_q[IW-1:0]));
        end else if (is_ctrl) begin
            rd_val = ctrl_q;
        end else begin
            rd_val = ram[ram_idx];
        end
    end

endmodule

// File: rtl/i2c_timereg_port.sv
module i2c_timereg_port
    import i2ctr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1101000,
    parameter int         ADDR_W      = 6,
    parameter int         TIME_REGS   = 7,
    parameter int         TO_TICKS    = 30,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_in,
    input  logic                          sda_in,
    output logic                          sda_pull,
    input  logic                          tick,
    input  logic [TIME_REGS*8-1:0]        live_time,
    input  logic                          osf_set,
    input  logic                          los_set,
    output logic                          tw_en,
    output logic [$clog2(TIME_REGS)-1:0]  tw_idx,
    output logic [7:0]                    tw_data,
    output logic                          chain_rst,
    output logic [7:0]                    ctrl_q
);
    localparam logic [3:0] BYTE_BITS = 4'd8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic to_fire;

    bus_state_t        state_q, state_d;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic [7:0]        txreg;
    logic              rw_q;
    logic              ptr_phase;
    logic              mack_ok;
    logic              sda_pull_q;
    logic              ptr_load_q;
    logic              wr_q;
    logic              adv_q;
    logic [7:0]        rd_val;
    logic              addr_hit;
    logic              byte_done;

    i2ctr_busin #(.STAGES(SYNC_STAGES)) u_busin (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2ctr_lowwatch #(.LIMIT(TO_TICKS)) u_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (scl_s),
        .tick  (tick),
        .fire  (to_fire)
    );

    i2ctr_regmap #(.ADDR_W(ADDR_W), .TIME_REGS(TIME_REGS)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_req  (start_det),
        .ptr_load  (ptr_load_q),
        .load_val  (shreg[ADDR_W-1:0]),
        .wr_req    (wr_q),
        .wr_val    (shreg),
        .adv_req   (adv_q),
        .live_time (live_time),
        .osf_set   (osf_set),
        .los_set   (los_set),
        .rd_val    (rd_val),
        .ctrl_q    (ctrl_q),
        .tw_en     (tw_en),
        .tw_idx    (tw_idx),
        .tw_data   (tw_data),
        .chain_rst (chain_rst)
    );

    assign addr_hit  = shreg[7:1] == DEV_ADDR;
    assign byte_done = scl_fall && (bit_cnt == BYTE_BITS);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (to_fire) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_IGNORE:   state_d = ST_IGNORE;
                ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)  state_d = rw_q ? ST_TXB : ST_RXB;
                ST_RXB:      if (byte_done) state_d = ST_RXB_ACK;
                ST_RXB_ACK:  if (scl_fall)  state_d = ST_RXB;
                ST_TXB:      if (byte_done) state_d = ST_MACK;
                ST_MACK:     if (scl_fall)  state_d = mack_ok ? ST_TXB : ST_IGNORE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            txreg      <= '0;
            rw_q       <= 1'b0;
            ptr_phase  <= 1'b0;
            mack_ok    <= 1'b0;
            sda_pull_q <= 1'b0;
            ptr_load_q <= 1'b0;
            wr_q       <= 1'b0;
            adv_q      <= 1'b0;
        end else begin
            ptr_load_q <= 1'b0;
            wr_q       <= 1'b0;
            adv_q      <= 1'b0;
            if (to_fire || start_det || stop_det) begin
                sda_pull_q <= 1'b0;
                bit_cnt    <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE, ST_IGNORE: begin
                        sda_pull_q <= 1'b0;
                    end
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done && addr_hit) begin
                            sda_pull_q <= 1'b1;
                            rw_q       <= shreg[0];
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rw_q) begin
                                txreg      <= {rd_val[6:0], 1'b0};
                                sda_pull_q <= ~rd_val[7];
                                bit_cnt    <= 4'd1;
                            end else begin
                                sda_pull_q <= 1'b0;
                                bit_cnt    <= '0;
                                ptr_phase  <= 1'b1;
                            end
                        end
                    end
                    ST_RXB: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            sda_pull_q <= 1'b1;
                            if (ptr_phase) ptr_load_q <= 1'b1;
                            else           wr_q       <= 1'b1;
                        end
                    end
                    ST_RXB_ACK: begin
                        if (scl_fall) begin
                            sda_pull_q <= 1'b0;
                            bit_cnt    <= '0;
                            ptr_phase  <= 1'b0;
                        end
                    end
                    ST_TXB: begin
                        if (byte_done) begin
                            sda_pull_q <= 1'b0;
                            adv_q      <= 1'b1;
                        end else if (scl_fall) begin
                            sda_pull_q <= ~txreg[7];
                            txreg      <= {txreg[6:0], 1'b0};
                            bit_cnt    <= bit_cnt + 1'b1;
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= ~sda_s;
                        end else if (scl_fall && mack_ok) begin
                            txreg      <= {rd_val[6:0], 1'b0};
                            sda_pull_q <= ~rd_val[7];
                            bit_cnt    <= 4'd1;
                        end
                    end
                endcase
            end
        end
    end

    assign sda_pull = sda_pull_q;

endmodule

// File: rtl/i2ctr_checker.sv
module i2ctr_checker
    import i2ctr_pkg::*;
#(
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input bus_state_t    state,
    input logic          sda_pull,
    input logic          scl_s,
    input logic          to_fire,
    input logic          tw_en,
    input logic [IW-1:0] tw_idx,
    input logic [7:0]    tw_data,
    input logic          chain_rst,
    input logic [7:0]    ctrl_q,
    input logic          osf_set,
    input logic          los_set
);
    // R9: SDA drive only changes while SCL is low.
    p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_s);

    // R8: watchdog expiry releases SDA and parks in IDLE.
    p_timeout_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        to_fire |=> (!sda_pull && state == ST_IDLE));

    // R2: silent states never drive the bus.
    p_quiet_states_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE || state == ST_IDLE) |-> !sda_pull);

    // R7: live-counter writes happen only while the byte is acknowledged.
    p_write_in_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tw_en |-> (state == ST_RXB_ACK && sda_pull));

    // R7: divider restart only on a seconds write.
    p_chain_on_sec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chain_rst |-> (tw_en && tw_idx == '0));

    // R11: fixed-zero bits never reach the counters.
    p_zero_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tw_en |-> ((tw_data & ~live_mask(3'(tw_idx))) == 8'h00));

    // R10: sticky flags rise only from hardware set inputs.
    p_osf_no_bus_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[5]) |-> $past(osf_set));
    p_los_no_bus_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[3]) |-> $past(los_set));

endmodule

bind i2c_timereg_port i2ctr_checker #(.IW($clog2(TIME_REGS))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .sda_pull  (sda_pull),
    .scl_s     (scl_s),
    .to_fire   (to_fire),
    .tw_en     (tw_en),
    .tw_idx    (tw_idx),
    .tw_data   (tw_data),
    .chain_rst (chain_rst),
    .ctrl_q    (ctrl_q),
    .osf_set   (osf_set),
    .los_set   (los_set)
);

// File: tb/tb_i2c_timereg_port.sv
`timescale 1ns/1ps
module tb_i2c_timereg_port;

    localparam int TO_TICKS = 12;
    localparam int TICKDIV  = 20;
    localparam int Q        = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda_low = 1'b0;
    logic        tick = 1'b0;
    logic [55:0] live_time = '0;
    logic        osf_set = 1'b0;
    logic        los_set = 1'b0;
    logic        sda_pull;
    logic        tw_en;
    logic [2:0]  tw_idx;
    logic [7:0]  tw_data;
    logic        chain_rst;
    logic [7:0]  ctrl_q;
    logic        sda_bus;

    assign sda_bus = !(m_sda_low || sda_pull);

    always #4 clk = ~clk;

    i2c_timereg_port #(.TO_TICKS(TO_TICKS)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .sda_pull(sda_pull), .tick(tick), .live_time(live_time),
        .osf_set(osf_set), .los_set(los_set), .tw_en(tw_en), .tw_idx(tw_idx),
        .tw_data(tw_data), .chain_rst(chain_rst), .ctrl_q(ctrl_q)
    );

    int tick_cnt = 0;
    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == TICKDIV - 1) ? 0 : tick_cnt + 1;
        tick     <= (tick_cnt == TICKDIV - 1);
    end

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    int   tw_cnt = 0;
    int   chain_cnt = 0;
    int   r9_bad = 0;
    logic prev_pull = 1'b0;
    logic [7:0] got_tw [8];

    always @(negedge clk) begin
        if (rst_n) begin
            if (tw_en) begin
                tw_cnt++;
                got_tw[tw_idx] = tw_data;
            end
            if (chain_rst) chain_cnt++;
            if (sda_pull != prev_pull && m_scl) r9_bad++;
        end
        prev_pull = sda_pull;
    end

    // Bench model of the map.
    logic [7:0] exp_ram [64];
    logic [7:0] exp_ctrl = 8'hB3;
    logic [7:0] m_shadow [7];
    logic [5:0] m_ptr = '0;

    function automatic logic [7:0] fmask(input int i);
        case (i)
            1, 2: return 8'h7F;
            3:    return 8'h07;
            4:    return 8'h3F;
            5:    return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic [5:0] a);
        if (a < 7)       return m_shadow[a] & fmask(int'(a));
        else if (a == 7) return exp_ctrl;
        else             return exp_ram[a];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic clkn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic take_snap();
        for (int i = 0; i < 7; i++) m_shadow[i] = live_time[i*8 +: 8];
    endtask

    task automatic model_adv();
        if (m_ptr == 6'h3F) begin
            m_ptr = 0;
            take_snap();
        end else begin
            m_ptr = m_ptr + 1;
        end
    endtask

    task automatic bus_start();
        m_scl = 0; clkn(Q);
        m_sda_low = 0; clkn(Q);
        m_scl = 1; clkn(Q);
        take_snap();
        m_sda_low = 1; clkn(Q);
        m_scl = 0; clkn(Q);
    endtask

    task automatic bus_stop();
        m_scl = 0; clkn(Q);
        m_sda_low = 1; clkn(Q);
        m_scl = 1; clkn(Q);
        m_sda_low = 0; clkn(Q);
    endtask

    task automatic put_bit(input bit b);
        m_scl = 0; clkn(Q);
        m_sda_low = !b; clkn(Q);
        m_scl = 1; clkn(2*Q);
        m_scl = 0;
    endtask

    task automatic get_bit(output bit b);
        m_sda_low = 0; clkn(2*Q);
        m_scl = 1; clkn(Q);
        b = sda_bus; clkn(Q);
        m_scl = 0;
    endtask

    task automatic wr_byte(input logic [7:0] v, output bit ack);
        bit ab;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ab);
        ack = !ab;
    endtask

    task automatic rd_byte(output logic [7:0] v, input bit ack);
        bit b;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            v = {v[6:0], b};
        end
        put_bit(!ack);
    endtask

    task automatic open_wr(input logic [7:0] ptr, input string req);
        bit a;
        bus_start();
        wr_byte(8'hD0, a); chk(a, {"R1 write address ack ", req}, a, 1);
        wr_byte(ptr, a);   chk(a, {"R3 pointer byte ack ", req}, a, 1);
        m_ptr = ptr[5:0];
    endtask

    task automatic open_rd_at(input logic [7:0] ptr, input string req);
        bit a;
        open_wr(ptr, req);
        bus_start();
        wr_byte(8'hD1, a); chk(a, {"R4 read address ack ", req}, a, 1);
    endtask

    task automatic open_rd_cur(input string req);
        bit a;
        bus_start();
        wr_byte(8'hD1, a); chk(a, {"R4 read address ack ", req}, a, 1);
    endtask

    task automatic wr_chk(input logic [7:0] v, input string req);
        bit a;
        wr_byte(v, a);
        chk(a, {req, " data ack"}, a, 1);
        if (m_ptr == 7)
            exp_ctrl = (v & ~8'h28) | (exp_ctrl & v & 8'h28);
        else if (m_ptr >= 8)
            exp_ram[m_ptr] = v;
        model_adv();
    endtask

    task automatic rd_chk(input string req, input bit ack);
        logic [7:0] v, e;
        e = exp_rd(m_ptr);
        rd_byte(v, ack);
        chk(v == e, req, v, e);
        model_adv();
    endtask

    task automatic rand_live();
        live_time = {$urandom(), $urandom()};
    endtask

    initial begin
        int unsigned sd;
        bit a;
        logic [7:0] v;
        int tw0, ch0;
        sd = $urandom(32'hC0FFEE);
        for (int i = 0; i < 64; i++) exp_ram[i] = 8'h00;
        for (int i = 0; i < 8; i++) got_tw[i] = 8'h00;
        rand_live();
        clkn(5);
        rst_n = 1;
        clkn(5);

        // Reset state (R10, R9)
        chk(ctrl_q == 8'hB3, "R10 control reset value", ctrl_q, 8'hB3);
        chk(sda_pull == 1'b0, "R9 bus released after reset", sda_pull, 0);

        // Directed write then read back (R1, R3, R4)
        open_wr(8'h10, "R3 directed");
        wr_chk(8'hA5, "R3"); wr_chk(8'h3C, "R3"); wr_chk(8'h00, "R3"); wr_chk(8'hFF, "R3");
        bus_stop();
        open_rd_at(8'h10, "R4 directed");
        for (int i = 0; i < 3; i++) rd_chk("R4 directed readback", 1);
        rd_chk("R4 directed readback", 0);
        bus_stop();
        // R4: continue at current pointer with a plain START
        open_rd_cur("R4 continue");
        rd_chk("R4 read continues at pointer", 0);
        bus_stop();

        // Random RAM bursts (R3, R4)
        for (int k = 0; k < 12; k++) begin
            int len, p;
            len = int'($urandom_range(5, 1));
            p   = int'($urandom_range(63 - len, 8));
            open_wr(8'(p), "R3 random");
            for (int j = 0; j < len; j++) wr_chk(8'($urandom()), "R3 random");
            bus_stop();
            open_rd_at(8'(p), "R4 random");
            for (int j = 0; j < len; j++) rd_chk("R4 random readback", j != len - 1);
            bus_stop();
        end

        // Address mismatch (R2)
        bus_start();
        wr_byte(8'hA0, a); chk(!a, "R2 foreign address not acked", a, 0);
        wr_byte(8'h20, a); chk(!a, "R2 byte after foreign address ignored", a, 0);
        wr_byte(8'h55, a); chk(!a, "R2 data after foreign address ignored", a, 0);
        bus_stop();
        bus_start();
        wr_byte(8'hD2, a); chk(!a, "R2 neighbour address not acked", a, 0);
        bus_stop();
        open_rd_at(8'h20, "R2 verify");
        rd_chk("R2 RAM unchanged by foreign transfer", 0);
        bus_stop();

        // Wrap and wrap-time snapshot (R5, R6)
        open_wr(8'h3E, "R5 wrap");
        wr_chk(8'h5A, "R5"); wr_chk(8'hC3, "R5");
        bus_stop();
        rand_live();
        open_rd_at(8'h3E, "R5 wrap read");
        rand_live();
        rd_chk("R5 RAM byte 3Eh", 1);
        rd_chk("R5 RAM byte 3Fh", 1);
        rd_chk("R6 wrap snapshot seconds", 1);
        rd_chk("R6 wrap snapshot minutes", 0);
        bus_stop();

        // Coherent burst while live values move (R6, R11, R5)
        live_time = {56{1'b1}};
        open_rd_at(8'h00, "R6 burst");
        rand_live();
        for (int i = 0; i < 7; i++) rd_chk("R6 R11 shadow held and masked", 1);
        rd_chk("R5 control byte at 07h", 1);
        rd_chk("R5 RAM byte at 08h", 0);
        bus_stop();
        open_rd_at(8'h00, "R6 new START");
        rd_chk("R6 START reloads shadow", 0);
        bus_stop();

        // Live-counter writes (R7, R11)
        tw0 = tw_cnt; ch0 = chain_cnt;
        open_wr(8'h00, "R7 time write");
        wr_chk(8'hFF, "R7");
        chk(tw_cnt == tw0 + 1, "R7 write issued during acknowledge", tw_cnt - tw0, 1);
        for (int i = 1; i < 7; i++) wr_chk(8'hFF, "R7");
        bus_stop();
        chk(tw_cnt == tw0 + 7, "R7 seven time writes", tw_cnt - tw0, 7);
        chk(chain_cnt == ch0 + 1, "R7 one divider restart", chain_cnt - ch0, 1);
        for (int i = 0; i < 7; i++)
            chk(got_tw[i] == fmask(i), "R11 write port masks fixed zeros", got_tw[i], fmask(i));
        open_wr(8'h02, "R7 hours write");
        wr_chk(8'h12, "R7");
        bus_stop();
        chk(chain_cnt == ch0 + 1, "R7 no restart for non-seconds write", chain_cnt - ch0, 1);
        chk(got_tw[2] == 8'h12, "R7 hours write data", got_tw[2], 8'h12);

        // Control flags (R10)
        open_wr(8'h07, "R10"); wr_chk(8'h00, "R10"); bus_stop();
        chk(ctrl_q == exp_ctrl, "R10 write zero clears all", ctrl_q, exp_ctrl);
        open_wr(8'h07, "R10"); wr_chk(8'hFF, "R10"); bus_stop();
        chk(ctrl_q == 8'hD7, "R10 writing one does not set flags", ctrl_q, 8'hD7);
        @(negedge clk) osf_set = 1; @(negedge clk) osf_set = 0;
        exp_ctrl = exp_ctrl | 8'h20;
        clkn(2);
        chk(ctrl_q == 8'hF7, "R10 hardware sets flag", ctrl_q, 8'hF7);
        open_wr(8'h07, "R10"); wr_chk(8'hFF, "R10"); bus_stop();
        chk(ctrl_q == 8'hF7, "R10 writing one keeps flag", ctrl_q, 8'hF7);
        @(negedge clk) los_set = 1; @(negedge clk) los_set = 0;
        exp_ctrl = exp_ctrl | 8'h08;
        open_wr(8'h07, "R10"); wr_chk(8'hDF, "R10"); bus_stop();
        chk(ctrl_q == 8'hDF, "R10 selective clear", ctrl_q, 8'hDF);
        open_rd_at(8'h07, "R10 readback");
        rd_chk("R10 control readback", 0);
        bus_stop();

        // Master NACK (R12)
        open_wr(8'h30, "R12"); wr_chk(8'h40, "R12"); wr_chk(8'h41, "R12"); bus_stop();
        open_rd_at(8'h30, "R12 read");
        rd_chk("R12 byte before NACK", 0);
        v = '0;
        for (int i = 0; i < 8; i++) begin
            bit b;
            get_bit(b);
            v = {v[6:0], b};
        end
        chk(v == 8'hFF, "R12 released after NACK", v, 8'hFF);
        bus_stop();
        open_rd_cur("R12 pointer advanced");
        rd_chk("R12 next byte after NACK", 0);
        bus_stop();

        // Bus timeout (R8)
        open_wr(8'h20, "R8"); wr_chk(8'h00, "R8"); bus_stop();
        open_rd_at(8'h20, "R8 read");
        clkn(Q);
        chk(sda_pull == 1'b1, "R8 slave driving data bit", sda_pull, 1);
        clkn((TO_TICKS - 3) * TICKDIV);
        chk(sda_pull == 1'b1, "R8 short low hold has no effect", sda_pull, 1);
        clkn(6 * TICKDIV);
        chk(sda_pull == 1'b0, "R8 timeout releases SDA", sda_pull, 0);
        open_rd_cur("R8 START after timeout");
        rd_chk("R8 read after timeout", 0);
        bus_stop();

        chk(r9_bad == 0, "R9 no SDA change with SCL high", r9_bad, 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule